// File: doc/BRIEF.md
# Multi-Accumulator Multiply-Accumulate Unit

This block is a pipelined multiply-accumulate engine for signal-processing loops. Each accepted operation carries two 32-bit operands and a set of control bits. The control bits pick the operand width (low 16 bits or full 32 bits) and the arithmetic (unsigned integer, signed integer or signed fraction). They also choose whether the product is added to or subtracted from the target, whether an overflow saturates, and which of four 48-bit accumulators is the target. The product passes through a fixed four-stage pipeline: operand capture, multiply, align/negate and accumulate. The accumulate stage writes the accumulator.

Operations are issued through a valid/ready handshake. Ready falls while an earlier operation aimed at the same accumulator is still in flight, so a dependent operation always sees the retired value. A load port writes an accumulator directly. A read port returns any accumulator as two 32-bit words: the low word, then the sign-extended upper part. Each accumulator has a sticky overflow flag.

Top module: `mac_unit`

## Requirements
- R1: Four independent 48-bit accumulators are selected by the 2-bit index `op_acc`. An operation changes only the accumulator it targets.
- R2: An operation accepted at clock edge n (`op_valid` and `op_ready` both high) changes its accumulator at edge n+3. The new value is visible on the read port after that edge and not before.
- R3: With `op_wide`=0 only bits [15:0] of each operand are used. With `op_wide`=1 all 32 bits are used.
- R4: With `op_signed`=1 operands are two's complement. With `op_signed`=0 they are zero-extended. The accumulator is always a signed 48-bit value.
- R5: With `op_frac`=1 operands are taken as signed whatever `op_signed` is, and the product is doubled (shifted left by one) before accumulation.
- R6: `op_sub`=0 adds the product to the accumulator. `op_sub`=1 subtracts it.
- R7: If the exact sum lies outside the signed 48-bit range, `ovf_flags[k]` of the target k goes high. It stays high until a load to that accumulator. Without saturation the stored value is the low 48 bits of the exact sum.
- R8: With `op_sat`=1, an overflowing result is stored as 0x7FFF_FFFF_FFFF (positive excess) or 0x8000_0000_0000 (negative excess).
- R9: `op_ready` is low exactly while an accepted operation targeting accumulator `op_acc` has not yet written it. `op_ready` does not depend on `op_valid`.
- R10: `ld_valid` writes `ld_data` into accumulator `ld_acc` at the next edge and clears its overflow flag. If a pipeline write hits the same accumulator at that edge, the load wins.
- R11: `rd_hi`=0 returns bits [31:0] of accumulator `rd_sel`. `rd_hi`=1 returns bits [47:32] sign-extended to 32 bits. The read is combinational.
- R12: After a synchronous active-low reset, all accumulators read zero, all flags are low and the pipeline is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Operation can be accepted (no pending write to `op_acc`) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_acc | input | 2 | Target accumulator index |
| op_frac | input | 1 | Signed fractional mode |
| op_signed | input | 1 | Signed integer operands |
| op_wide | input | 1 | 1: 32-bit operands, 0: low 16 bits |
| op_sub | input | 1 | Subtract the product instead of adding |
| op_sat | input | 1 | Saturate on overflow |
| ld_valid | input | 1 | Load accumulator |
| ld_acc | input | 2 | Accumulator to load |
| ld_data | input | 48 | Load value |
| rd_sel | input | 2 | Accumulator to read |
| rd_hi | input | 1 | 0: low word, 1: sign-extended upper part |
| rd_data | output | 32 | Read word |
| ovf_flags | output | 4 | Sticky overflow flag per accumulator |

## Verification
The bench builds the unit with its default parameters: 32-bit operands, 16-bit narrow mode, four 48-bit accumulators. With these values, full-width unsigned and fractional products exceed the accumulator range within a single operation. Together with loads of values near both extremes, this makes wrap, saturation and sticky flags common under random stimulus. The four accumulators make same-target stalls and independent-target issue both frequent, so the hazard logic and the load-versus-write collision are reached without directed setup.

// File: rtl/mac_pkg.sv
// Shared sizes and the per-operation control word of the multiply-accumulate unit.
// Assumes every module of the unit is built with these defaults.
package mac_pkg;
    localparam int DATA_W    = 32;
    localparam int HALF_W    = 16;
    localparam int ACC_W     = 48;
    localparam int N_ACC     = 4;
    localparam int ACC_IDX_W = $clog2(N_ACC);
    localparam int N_STAGE   = 3;   // pipeline registers ahead of the accumulator write

    typedef struct packed {
        logic                 frac;
        logic                 sgn;
        logic                 wide;
        logic                 sub;
        logic                 sat;
        logic [ACC_IDX_W-1:0] acc;
    } mac_ctl_t;
endpackage

// File: rtl/mac_opfmt.sv
// Operand formatter: picks the narrow or full-width field of a raw operand
// and extends it by sign or zero to one bit more than the data width.
// Assumes the narrow field sits in the low HALF_W bits.
module mac_opfmt #(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic [DATA_W-1:0]  raw,
    input  logic               sgn,
    input  logic               wide,
    output logic signed [DATA_W:0] ext
);
    localparam int PAD_W = DATA_W - HALF_W + 1;

    // Select field and extend it.
    always_comb begin
        if (wide)
            ext = {sgn & raw[DATA_W-1], raw};
        else
            ext = {{PAD_W{sgn & raw[HALF_W-1]}}, raw[HALF_W-1:0]};
    end
endmodule

// File: rtl/mac_pipe.sv
// Three pipeline registers ahead of the accumulator: operand capture,
// multiply, then align (fraction doubling) and negate. Reports each stage's
// valid bit and target so the top can detect pending writes.
// Assumes the caller only issues when no stage targets the same accumulator.
module mac_pipe
    import mac_pkg::*;
#(
    parameter int OPX_W = DATA_W + 1,
    parameter int SUM_W = 2 * OPX_W + 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  mac_ctl_t                     in_ctl,
    input  logic signed [OPX_W-1:0]      in_a,
    input  logic signed [OPX_W-1:0]      in_b,
    output logic [N_STAGE-1:0]           pend_valid,
    output logic [N_STAGE-1:0][ACC_IDX_W-1:0] pend_acc,
    output logic                         out_valid,
    output mac_ctl_t                     out_ctl,
    output logic signed [SUM_W-1:0]      out_term
);
    localparam int PROD_W = 2 * OPX_W;

    logic                     v1, v2, v3;
    mac_ctl_t                 c1, c2, c3;
    logic signed [OPX_W-1:0]  a1, b1;
    logic signed [PROD_W-1:0] p2;
    logic signed [SUM_W-1:0]  t3;
    logic signed [SUM_W-1:0]  aligned;

    // Valid bits advance one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
        end
    end

    // Stage-two product widened, doubled in fractional mode.
    always_comb begin
        aligned = {{(SUM_W-PROD_W){p2[PROD_W-1]}}, p2};
        if (c2.frac)
            aligned = aligned <<< 1;
    end

    // Datapath registers: capture, multiply, align/negate.
    always_ff @(posedge clk) begin
        c1 <= in_ctl;
        a1 <= in_a;
        b1 <= in_b;
        c2 <= c1;
        p2 <= a1 * b1;
        c3 <= c2;
        t3 <= c2.sub ? -aligned : aligned;
    end

    assign pend_valid = {v3, v2, v1};
    assign pend_acc   = {c3.acc, c2.acc, c1.acc};
    assign out_valid  = v3;
    assign out_ctl    = c3;
    assign out_term   = t3;

    p_stage1_adv_r2: assert property (@(posedge clk) disable iff (!rst_n) v1 |=> v2);
    p_stage2_adv_r2: assert property (@(posedge clk) disable iff (!rst_n) v2 |=> v3);
    p_stage_idle_r2: assert property (@(posedge clk) disable iff (!rst_n) !v2 |=> !v3);
endmodule

// File: rtl/mac_acc_bank.sv
// Accumulator storage: adds the pipeline term to the target accumulator,
// detects 48-bit overflow, optionally saturates, keeps sticky flags, serves
// the load port (which has priority) and the two-word read port.
// Assumes at most one pipeline write per clock.
module mac_acc_bank
    import mac_pkg::*;
#(
    parameter int SUM_W = 2 * (DATA_W + 1) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  mac_ctl_t                wr_ctl,
    input  logic signed [SUM_W-1:0] wr_term,
    input  logic                    ld_valid,
    input  logic [ACC_IDX_W-1:0]    ld_acc,
    input  logic [ACC_W-1:0]        ld_data,
    input  logic [ACC_IDX_W-1:0]    rd_sel,
    input  logic                    rd_hi,
    output logic [DATA_W-1:0]       rd_data,
    output logic [N_ACC-1:0]        ovf
);
    localparam int EXT_W = SUM_W - ACC_W;
    localparam int HI_PAD = 2 * DATA_W - ACC_W;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0]        acc_q [N_ACC];
    logic signed [SUM_W-1:0] sum;
    logic                    over;
    logic [ACC_W-1:0]        result;
    logic [ACC_W-1:0]        rd_word;

    // Exact sum, overflow detection and saturation.
    always_comb begin
        sum    = {{EXT_W{acc_q[wr_ctl.acc][ACC_W-1]}}, acc_q[wr_ctl.acc]} + wr_term;
        over   = sum[SUM_W-1:ACC_W-1] != {(EXT_W+1){sum[SUM_W-1]}};
        result = sum[ACC_W-1:0];
        if (over && wr_ctl.sat)
            result = sum[SUM_W-1] ? ACC_MIN : ACC_MAX;
    end

    // Accumulator and flag update, load first.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N_ACC; k++) begin
            if (!rst_n) begin
                acc_q[k] <= '0;
                ovf[k]   <= 1'b0;
            end else if (ld_valid && ld_acc == ACC_IDX_W'(k)) begin
                acc_q[k] <= ld_data;
                ovf[k]   <= 1'b0;
            end else if (wr_valid && wr_ctl.acc == ACC_IDX_W'(k)) begin
                acc_q[k] <= result;
                ovf[k]   <= ovf[k] | over;
            end
        end
    end

    // Two-word read port.
    always_comb begin
        rd_word = acc_q[rd_sel];
        rd_data = rd_hi ? {{HI_PAD{rd_word[ACC_W-1]}}, rd_word[ACC_W-1:DATA_W]}
                        : rd_word[DATA_W-1:0];
    end

    for (genvar i = 0; i < N_ACC; i++) begin : g_chk
        p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] && !(ld_valid && ld_acc == ACC_IDX_W'(i)) |=> ovf[i]);
        p_load_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ld_valid && ld_acc == ACC_IDX_W'(i) |=> !ovf[i] && acc_q[i] == $past(ld_data));
        p_sat_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_valid && wr_ctl.acc == ACC_IDX_W'(i) && wr_ctl.sat && over
            && !(ld_valid && ld_acc == ACC_IDX_W'(i))
            |=> acc_q[i] == ACC_MAX || acc_q[i] == ACC_MIN);
    end
endmodule

// File: rtl/mac_unit.sv
// Top of the multiply-accumulate unit: formats operands, stalls issue while
// the target accumulator has a write in flight, and joins pipeline and bank.
// Assumes inputs are synchronous to clk.
module mac_unit
    import mac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    output logic                 op_ready,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    input  logic [ACC_IDX_W-1:0] op_acc,
    input  logic                 op_frac,
    input  logic                 op_signed,
    input  logic                 op_wide,
    input  logic                 op_sub,
    input  logic                 op_sat,
    input  logic                 ld_valid,
    input  logic [ACC_IDX_W-1:0] ld_acc,
    input  logic [ACC_W-1:0]     ld_data,
    input  logic [ACC_IDX_W-1:0] rd_sel,
    input  logic                 rd_hi,
    output logic [DATA_W-1:0]    rd_data,
    output logic [N_ACC-1:0]     ovf_flags
);
    localparam int OPX_W = DATA_W + 1;
    localparam int SUM_W = 2 * OPX_W + 2;

    mac_ctl_t                          ctl;
    logic signed [OPX_W-1:0]           a_ext, b_ext;
    logic [N_STAGE-1:0]                pend_valid;
    logic [N_STAGE-1:0][ACC_IDX_W-1:0] pend_acc;
    logic [N_STAGE-1:0]                hit;
    logic                              wr_valid;
    mac_ctl_t                          wr_ctl;
    logic signed [SUM_W-1:0]           wr_term;

    // Pack the control word; fractional mode forces signed operands.
    always_comb begin
        ctl.frac = op_frac;
        ctl.sgn  = op_signed | op_frac;
        ctl.wide = op_wide;
        ctl.sub  = op_sub;
        ctl.sat  = op_sat;
        ctl.acc  = op_acc;
    end

    for (genvar s = 0; s < N_STAGE; s++) begin : g_hit
        assign hit[s] = pend_valid[s] && pend_acc[s] == op_acc;
    end

    assign op_ready = ~|hit;

    mac_opfmt #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_fmt_a (
        .raw(op_a), .sgn(ctl.sgn), .wide(op_wide), .ext(a_ext));
    mac_opfmt #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_fmt_b (
        .raw(op_b), .sgn(ctl.sgn), .wide(op_wide), .ext(b_ext));

    mac_pipe #(.OPX_W(OPX_W), .SUM_W(SUM_W)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(op_valid && op_ready), .in_ctl(ctl),
        .in_a(a_ext), .in_b(b_ext),
        .pend_valid(pend_valid), .pend_acc(pend_acc),
        .out_valid(wr_valid), .out_ctl(wr_ctl), .out_term(wr_term));

    mac_acc_bank #(.SUM_W(SUM_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ctl(wr_ctl), .wr_term(wr_term),
        .ld_valid(ld_valid), .ld_acc(ld_acc), .ld_data(ld_data),
        .rd_sel(rd_sel), .rd_hi(rd_hi), .rd_data(rd_data), .ovf(ovf_flags));

    p_single_pend_01_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_valid[0] && pend_valid[1] && pend_acc[0] == pend_acc[1]));
    p_single_pend_02_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_valid[0] && pend_valid[2] && pend_acc[0] == pend_acc[2]));
    p_single_pend_12_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_valid[1] && pend_valid[2] && pend_acc[1] == pend_acc[2]));
endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
    localparam logic signed [67:0] MAXV = 68'sh7FFF_FFFF_FFFF;
    localparam logic signed [67:0] MINV = -68'sh8000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 0, op_frac = 0, op_signed = 0, op_wide = 0, op_sub = 0, op_sat = 0;
    logic [31:0] op_a = 0, op_b = 0;
    logic [1:0]  op_acc = 0, ld_acc = 0, rd_sel = 0;
    logic        ld_valid = 0, rd_hi = 0;
    logic [47:0] ld_data = 0;
    logic        op_ready;
    logic [31:0] rd_data;
    logic [3:0]  ovf_flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_a(op_a), .op_b(op_b), .op_acc(op_acc), .op_frac(op_frac),
        .op_signed(op_signed), .op_wide(op_wide), .op_sub(op_sub), .op_sat(op_sat),
        .ld_valid(ld_valid), .ld_acc(ld_acc), .ld_data(ld_data),
        .rd_sel(rd_sel), .rd_hi(rd_hi), .rd_data(rd_data), .ovf_flags(ovf_flags));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [47:0]        m_acc [4];
    logic [3:0]         m_ovf;
    bit                 m_pv [3];
    logic [1:0]         m_pa [3];
    bit                 m_ps [3];
    logic signed [67:0] m_pt [3];
    logic signed [67:0] m_sum;
    bit                 m_rdy;

    function automatic logic signed [67:0] mterm(input logic [31:0] a, b,
                                                 input logic fr, sg, wd, sb);
        logic signed [67:0] x, y, p;
        logic s;
        s = fr | sg;
        x = wd ? (s ? {{36{a[31]}}, a} : {36'd0, a}) : (s ? {{52{a[15]}}, a[15:0]} : {52'd0, a[15:0]});
        y = wd ? (s ? {{36{b[31]}}, b} : {36'd0, b}) : (s ? {{52{b[15]}}, b[15:0]} : {52'd0, b[15:0]});
        p = x * y;
        if (fr) p = p <<< 1;
        if (sb) p = -p;
        return p;
    endfunction

    function automatic bit mready(input logic [1:0] a);
        for (int i = 0; i < 3; i++)
            if (m_pv[i] && m_pa[i] == a) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] mread(input logic [1:0] s, input logic h);
        return h ? {{16{m_acc[s][47]}}, m_acc[s][47:32]} : m_acc[s][31:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_acc[i] = '0;
            m_ovf = '0;
            for (int i = 0; i < 3; i++) m_pv[i] = 0;
        end else begin
            m_rdy = mready(op_acc);
            if (m_pv[2]) begin
                m_sum = {{20{m_acc[m_pa[2]][47]}}, m_acc[m_pa[2]]} + m_pt[2];
                if (m_sum > MAXV || m_sum < MINV) begin
                    m_ovf[m_pa[2]] = 1'b1;
                    if (m_ps[2]) m_acc[m_pa[2]] = (m_sum < 0) ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
                    else         m_acc[m_pa[2]] = m_sum[47:0];
                end else
                    m_acc[m_pa[2]] = m_sum[47:0];
            end
            if (ld_valid) begin
                m_acc[ld_acc] = ld_data;
                m_ovf[ld_acc] = 1'b0;
            end
            for (int i = 2; i > 0; i--) begin
                m_pv[i] = m_pv[i-1]; m_pa[i] = m_pa[i-1];
                m_ps[i] = m_ps[i-1]; m_pt[i] = m_pt[i-1];
            end
            m_pv[0] = op_valid && m_rdy;
            m_pa[0] = op_acc;
            m_ps[0] = op_sat;
            m_pt[0] = mterm(op_a, op_b, op_frac, op_signed, op_wide, op_sub);
        end
    end

    // Per-clock comparison of the ports against the model.
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk("R9 ready vs model", 64'(op_ready), 64'(mready(op_acc)));
            chk("R7 flags vs model", 64'(ovf_flags), 64'(m_ovf));
            chk("R11 read vs model", 64'(rd_data), 64'(mread(rd_sel, rd_hi)));
        end
    end

    // ---------------- directed helpers ----------------
    task automatic issue(input logic [1:0] acc, input logic [31:0] a, b,
                         input logic fr, sg, wd, sb, st);
        @(negedge clk);
        op_acc = acc; op_a = a; op_b = b;
        op_frac = fr; op_signed = sg; op_wide = wd; op_sub = sb; op_sat = st;
        op_valid = 1'b1;
        #1;
        while (!op_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic load(input logic [1:0] acc, input logic [47:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_acc = acc; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic rd64(input logic [1:0] s, output logic [63:0] v);
        logic [31:0] lo;
        rd_sel = s; rd_hi = 1'b0; #1; lo = rd_data;
        rd_hi = 1'b1; #1; v = {rd_data, lo};
    endtask

    logic [63:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12: reset state
        chk("R12 ready after reset", 64'(op_ready), 64'd1);
        chk("R12 flags after reset", 64'(ovf_flags), 64'd0);
        for (int i = 0; i < 4; i++) begin
            rd64(2'(i), v);
            chk("R12 accumulator zero", v, 64'd0);
        end

        // R2: latency of exactly three edges after the accept edge
        load(2, 48'd0);
        issue(2, 32'd5, 32'd7, 0, 1, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        rd64(2, v); chk("R2 not yet written", v, 64'd0);
        @(negedge clk);
        rd64(2, v); chk("R2 written at n+3", v, 64'd35);

        // R3: narrow mode ignores upper operand bits; wide uses them
        load(0, 48'd0);
        issue(0, 32'hFFFF_0003, 32'h0001_0004, 0, 1, 0, 0, 0); drain();
        rd64(0, v); chk("R3 narrow uses low half", v, 64'd12);
        load(0, 48'd0);
        issue(0, 32'h0001_0000, 32'h0001_0000, 0, 0, 1, 0, 0); drain();
        rd64(0, v); chk("R3 wide product 2^32", v, 64'h0000_0001_0000_0000);

        // R4: unsigned vs signed 16-bit
        load(1, 48'd0);
        issue(1, 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 0, 0, 0); drain();
        rd64(1, v); chk("R4 unsigned 0xFFFF squared", v, 64'h0000_0000_FFFE_0001);
        load(1, 48'd0);
        issue(1, 32'h0000_FFFF, 32'h0000_FFFF, 0, 1, 0, 0, 0); drain();
        rd64(1, v); chk("R4 signed -1 squared", v, 64'd1);

        // R5: fractional doubling, signed regardless of op_signed
        load(3, 48'd0);
        issue(3, 32'h0000_4000, 32'h0000_4000, 1, 0, 0, 0, 0); drain();
        rd64(3, v); chk("R5 Q15 half times half", v, 64'h0000_0000_2000_0000);
        load(3, 48'd0);
        issue(3, 32'h0000_FFFF, 32'h0000_0002, 1, 0, 0, 0, 0); drain();
        rd64(3, v); chk("R5 fraction negative", v, 64'hFFFF_FFFF_FFFF_FFFC);
        load(3, 48'd0);
        issue(3, 32'h4000_0000, 32'h0000_0100, 1, 1, 1, 0, 0); drain();
        rd64(3, v); chk("R5 wide fraction", v, 64'h0000_0080_0000_0000);

        // R6: subtract
        load(2, 48'd100);
        issue(2, 32'd3, 32'd4, 0, 1, 0, 1, 0); drain();
        rd64(2, v); chk("R6 subtract", v, 64'd88);

        // R7: wrap, sticky flag, cleared by load
        load(1, 48'h7FFF_FFFF_FFFF);
        issue(1, 32'd1, 32'd1, 0, 1, 0, 0, 0); drain();
        rd64(1, v); chk("R7 wrap to most negative", v, 64'hFFFF_8000_0000_0000);
        chk("R7 flag set", 64'(ovf_flags[1]), 64'd1);
        issue(1, 32'd1, 32'd1, 0, 1, 0, 0, 0); drain();
        chk("R7 flag sticky", 64'(ovf_flags[1]), 64'd1);
        load(1, 48'd5);
        chk("R10 load clears flag", 64'(ovf_flags[1]), 64'd0);

        // R8: saturation both directions
        load(1, 48'h7FFF_FFFF_FFFE);
        issue(1, 32'd2, 32'd3, 0, 1, 0, 0, 1); drain();
        rd64(1, v); chk("R8 clamp positive", v, 64'h0000_7FFF_FFFF_FFFF);
        load(1, 48'h8000_0000_0001);
        issue(1, 32'd1, 32'd5, 0, 1, 0, 1, 1); drain();
        rd64(1, v); chk("R8 clamp negative", v, 64'hFFFF_8000_0000_0000);
        chk("R8 flag with saturation", 64'(ovf_flags[1]), 64'd1);

        // R9: stall on pending write to same accumulator only
        issue(3, 32'd1, 32'd1, 0, 1, 0, 0, 0);
        op_acc = 3; #1; chk("R9 stall same acc", 64'(op_ready), 64'd0);
        op_acc = 0; #1; chk("R9 other acc ready", 64'(op_ready), 64'd1);
        @(negedge clk); @(negedge clk);
        op_acc = 3; #1; chk("R9 stall until written", 64'(op_ready), 64'd0);
        @(negedge clk);
        #1; chk("R9 ready after write", 64'(op_ready), 64'd1);

        // R1: independence of accumulators
        load(0, 48'd11); load(1, 48'd22); load(2, 48'd33); load(3, 48'd44);
        issue(2, 32'd2, 32'd2, 0, 0, 0, 0, 0); drain();
        rd64(0, v); chk("R1 acc0 untouched", v, 64'd11);
        rd64(2, v); chk("R1 acc2 updated", v, 64'd37);
        rd64(3, v); chk("R1 acc3 untouched", v, 64'd44);

        // R10: load beats a same-edge pipeline write
        load(0, 48'd0);
        issue(0, 32'd2, 32'd3, 0, 1, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        ld_valid = 1'b1; ld_acc = 0; ld_data = 48'd777;
        @(negedge clk);
        ld_valid = 1'b0;
        rd64(0, v); chk("R10 load wins collision", v, 64'd777);

        // Random traffic, checked every clock against the model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            op_valid  = $urandom_range(0, 1);
            op_a      = $urandom; op_b = $urandom;
            op_acc    = 2'($urandom); op_frac = 1'($urandom); op_signed = 1'($urandom);
            op_wide   = 1'($urandom); op_sub = 1'($urandom); op_sat = 1'($urandom);
            ld_valid  = ($urandom_range(0, 15) == 0);
            ld_acc    = 2'($urandom);
            case ($urandom_range(0, 2))
                0: ld_data = {16'($urandom), 32'($urandom)};
                1: ld_data = 48'h7FFF_FFFF_0000 + 48'($urandom_range(0, 65535));
                default: ld_data = 48'h8000_0000_0000 + 48'($urandom_range(0, 65535));
            endcase
            rd_sel = 2'($urandom); rd_hi = 1'($urandom);
        end
        @(negedge clk);
        op_valid = 0; ld_valid = 0;
        drain();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule